// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date as eight packed-BCD bytes. It advances on a one-cycle enable pulse that the surrounding logic raises at 100 Hz. The counted fields are hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. Each month ends on its correct last day, and February is handled for leap years up to the turn of the century.

The host sees all eight bytes at once on a 64-bit read bus. It replaces them as one set through a single-cycle load strobe. The hour byte picks either a 12-hour format with an AM/PM flag or a 24-hour format. The day-of-week byte also holds two control flags. One of them halts the count.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the read bus is 64'h00_01_01_31_00_00_00_00. Byte i sits at bits [8i+7:8i], with byte 0 = hundredths, 1 = seconds, 2 = minutes, 3 = hours, 4 = day of week, 5 = date, 6 = month, 7 = year. The value means 24-hour mode, 00:00:00.00, day 1, date 01, month 01, year 00, with both control flags in the day-of-week byte (bits 5 and 4) set.
- R2: When the halt flag is clear, each cycle with `tick` high adds one to the hundredths. Hundredths wrap 99 to 00 into seconds, seconds wrap 59 to 00 into minutes, and minutes wrap 59 to 00 into hours. All of these are BCD.
- R3: In 24-hour mode (hour bit 7 = 0), hour bits 5:0 hold the BCD hour 00-23. A step from 23 goes to 00 and advances the day.
- R4: In 12-hour mode (hour bit 7 = 1), bits 4:0 hold the BCD hour 01-12 and bit 5 is PM. Step 11 goes to 12 and toggles PM. Step 12 goes to 01 and keeps PM. The day advances only when 11 PM becomes 12 AM.
- R5: A day advance steps day-of-week bits 2:0 from 1 to 7, with 7 wrapping to 1. Bits 5 and 4 are kept.
- R6: A day advance past the last date of a month sets the date to 01 and steps the month. April, June, September and November end on 30. The other months, except February, end on 31.
- R7: February ends on 29 when the BCD year is a multiple of four, including 00. Otherwise it ends on 28.
- R8: The month wraps 12 to 01 and steps the year. The year wraps 99 to 00.
- R9: While day-of-week bit 5 is 1, ticks change nothing.
- R10: A cycle with `loadEn` high writes all eight bytes from `loadData` (same byte layout as R1) together. A tick in that same cycle is discarded.
- R11: Bits that are not used always read as 0, whatever value is written. The writable masks, from byte 7 down to byte 0, are FF, 1F, 3F, 37, BF, 7F, 7F, FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz count enable, one cycle wide |
| loadEn | input | 1 | Write all eight bytes this cycle |
| loadData | input | 64 | Byte set to load |
| regData | output | 64 | Current eight bytes |

## Verification
A wrong carry or wrap shows on `regData` one clock after the tick that should have caused it. An error in the carry chain needs a start value just below a rollover before it becomes visible. For that reason the stimulus mixes chosen start points at month, year, leap and noon/midnight edges with random valid loads that lean towards rollover. Every cycle is compared, so a fault is reported in the cycle it first appears. A bad load mask or a tick that leaks through a load shows up immediately on the read bus after the load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W   = 8;
  localparam int N_REGS  = 8;
  localparam int BUS_W   = REG_W * N_REGS;

  localparam logic [BUS_W-1:0] WRITE_MASK = 64'hFF_1F_3F_37_BF_7F_7F_FF;
  localparam logic [BUS_W-1:0] RESET_REGS = 64'h00_01_01_31_00_00_00_00;

  localparam int HALT_BIT  = 5;
  localparam int RSTEN_BIT = 4;
  localparam int MODE_BIT  = 7;
  localparam int PM_BIT    = 5;

  typedef struct packed {
    logic [REG_W-1:0] year;
    logic [REG_W-1:0] month;
    logic [REG_W-1:0] date;
    logic [REG_W-1:0] dow;
    logic [REG_W-1:0] hour;
    logic [REG_W-1:0] minute;
    logic [REG_W-1:0] second;
    logic [REG_W-1:0] hund;
  } rtcRegs_t;

  typedef struct packed {
    logic load;
    logic incHund;
    logic incSec;
    logic incMin;
    logic incHour;
    logic incDay;
    logic incMonth;
    logic incYear;
  } rtcStrobe_t;

  function automatic logic [REG_W-1:0] bcdInc(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    if (v == 8'h99)         r = '0;
    else if (v[3:0] >= 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                     r = {v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  function automatic logic [REG_W-1:0] hourNext(input logic [REG_W-1:0] h);
    logic [REG_W-1:0] r;
    if (h[MODE_BIT]) begin
      if (h[4:0] == 5'h11)      r = {1'b1, 1'b0, ~h[PM_BIT], 5'h12};
      else if (h[4:0] == 5'h12) r = {1'b1, 1'b0, h[PM_BIT], 5'h01};
      else                      r = {1'b1, 1'b0, h[PM_BIT], bcdInc({3'b000, h[4:0]})[4:0]};
    end else begin
      if (h[5:0] == 6'h23)      r = '0;
      else                      r = {2'b00, bcdInc({2'b00, h[5:0]})[5:0]};
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       loadEn,
  input  rtcRegs_t   regs,
  output rtcStrobe_t strb
);
  logic running, tickOk;
  logic hundMax, secMax, minMax, hourRoll, dateMax, monthMax;
  logic leapYear;
  logic [REG_W-1:0] lastDate;

  assign running = ~regs.dow[HALT_BIT];
  assign tickOk  = tick & running & ~loadEn;

  always_comb begin
    if (regs.year[4]) leapYear = (regs.year[3:0] == 4'h2) || (regs.year[3:0] == 4'h6);
    else              leapYear = (regs.year[3:0] == 4'h0) || (regs.year[3:0] == 4'h4) ||
                                 (regs.year[3:0] == 4'h8);
  end

  always_comb begin
    unique case (regs.month)
      8'h02:                      lastDate = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDate = 8'h30;
      default:                    lastDate = 8'h31;
    endcase
  end

  assign hundMax  = (regs.hund == 8'h99);
  assign secMax   = (regs.second == 8'h59);
  assign minMax   = (regs.minute == 8'h59);
  assign hourRoll = regs.hour[MODE_BIT] ? (regs.hour[PM_BIT] && regs.hour[4:0] == 5'h11)
                                        : (regs.hour[5:0] == 6'h23);
  assign dateMax  = (regs.date == lastDate);
  assign monthMax = (regs.month == 8'h12);

  always_comb begin
    strb          = '0;
    strb.load     = loadEn;
    strb.incHund  = tickOk;
    strb.incSec   = strb.incHund & hundMax;
    strb.incMin   = strb.incSec & secMax;
    strb.incHour  = strb.incMin & minMax;
    strb.incDay   = strb.incHour & hourRoll;
    strb.incMonth = strb.incDay & dateMax;
    strb.incYear  = strb.incMonth & monthMax;
  end

  // R10
  load_drops_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> !strb.incHund);

  // R9
  halt_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    regs.dow[HALT_BIT] |-> !strb.incHund);

  // R2
  carry_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incSec |-> (strb.incHund && regs.hund == 8'h99));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       strb,
  input  logic [BUS_W-1:0] loadData,
  output rtcRegs_t         regs
);
  rtcRegs_t regsQ;
  logic [BUS_W-1:0] loadMasked;

  for (genvar i = 0; i < N_REGS; i++) begin : g_mask
    assign loadMasked[i*REG_W +: REG_W] = loadData[i*REG_W +: REG_W] & WRITE_MASK[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regsQ <= RESET_REGS;
    end else if (strb.load) begin
      regsQ <= loadMasked;
    end else begin
      if (strb.incHund) regsQ.hund <= bcdInc(regsQ.hund);
      if (strb.incSec)  regsQ.second <= (regsQ.second == 8'h59) ? '0 : bcdInc(regsQ.second);
      if (strb.incMin)  regsQ.minute <= (regsQ.minute == 8'h59) ? '0 : bcdInc(regsQ.minute);
      if (strb.incHour) regsQ.hour <= hourNext(regsQ.hour);
      if (strb.incDay)
        regsQ.dow <= {regsQ.dow[7:3], (regsQ.dow[2:0] == 3'd7) ? 3'd1 : regsQ.dow[2:0] + 3'd1};
      if (strb.incMonth)    regsQ.date <= 8'h01;
      else if (strb.incDay) regsQ.date <= bcdInc(regsQ.date);
      if (strb.incMonth) regsQ.month <= (regsQ.month == 8'h12) ? 8'h01 : bcdInc(regsQ.month);
      if (strb.incYear)  regsQ.year <= bcdInc(regsQ.year);
    end
  end

  assign regs = regsQ;

  // R10
  load_takes_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (regsQ == ($past(loadData) & WRITE_MASK)));

  // R9
  halted_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && regsQ.dow[HALT_BIT]) |=> $stable(regsQ));

  // R6
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incMonth |=> (regsQ.date == 8'h01));

  // R3
  midnight_24_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incHour && !strb.load && !regsQ.hour[MODE_BIT] && regsQ.hour[5:0] == 6'h23)
      |=> (regsQ.hour == 8'h00));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             loadEn,
  input  logic [BUS_W-1:0] loadData,
  output logic [BUS_W-1:0] regData
);
  rtcRegs_t   regs;
  rtcStrobe_t strb;

  rtc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .loadEn (loadEn),
    .regs   (regs),
    .strb   (strb)
  );

  rtc_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadData (loadData),
    .regs     (regs)
  );

  assign regData = regs;
endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  localparam logic [63:0] MASK = 64'hFF_1F_3F_37_BF_7F_7F_FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic loadEn = 1'b0;
  logic [63:0] loadData = '0;
  logic [63:0] regData;
  logic [63:0] expV;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .loadEn(loadEn),
    .loadData(loadData), .regData(regData)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int monthLen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] s);
    int hu, se, mi, hr, dw, dt, mo, yr;
    bit m12, pm, dayAdv;
    logic [7:0] hb, db;
    if (s[37]) return s;
    hu = b2i(s[7:0]); se = b2i(s[15:8]); mi = b2i(s[23:16]);
    hb = s[31:24]; db = s[39:32];
    m12 = hb[7]; pm = hb[5];
    hr = m12 ? b2i({3'b000, hb[4:0]}) : b2i({2'b00, hb[5:0]});
    dw = int'(db[2:0]);
    dt = b2i(s[47:40]); mo = b2i(s[55:48]); yr = b2i(s[63:56]);
    dayAdv = 0;
    hu++;
    if (hu == 100) begin
      hu = 0; se++;
      if (se == 60) begin
        se = 0; mi++;
        if (mi == 60) begin
          mi = 0;
          if (m12) begin
            if (hr == 11) begin hr = 12; dayAdv = pm; pm = ~pm; end
            else if (hr == 12) hr = 1;
            else hr++;
          end else begin
            hr++;
            if (hr == 24) begin hr = 0; dayAdv = 1; end
          end
        end
      end
    end
    if (dayAdv) begin
      dw = (dw == 7) ? 1 : dw + 1;
      dt++;
      if (dt > monthLen(mo, yr)) begin
        dt = 1; mo++;
        if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
      end
    end
    hb = m12 ? {1'b1, 1'b0, pm, i2b(hr)[4:0]} : i2b(hr);
    db = {db[7:3], 3'(dw)};
    return {i2b(yr), i2b(mo), i2b(dt), db, hb, i2b(mi), i2b(se), i2b(hu)};
  endfunction

  task automatic check(input string req);
    nChecks++;
    if (regData !== expV) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, regData, expV);
    end
  endtask

  task automatic cyc(input bit t, input string req);
    tick = t;
    loadEn = 1'b0;
    @(negedge clk);
    if (t) expV = model(expV);
    check(req);
  endtask

  task automatic load(input logic [63:0] v, input bit t, input string req);
    loadEn = 1'b1;
    loadData = v;
    tick = t;
    @(negedge clk);
    loadEn = 1'b0;
    tick = 1'b0;
    expV = v & MASK;
    check(req);
  endtask

  function automatic logic [63:0] randState();
    int yr, mo, dt, hr, m12, pm;
    logic [7:0] hb, db;
    yr = $urandom % 100; mo = 1 + $urandom % 12;
    dt = ($urandom % 2) ? monthLen(mo, yr) : 1 + $urandom % monthLen(mo, yr);
    m12 = $urandom % 2; pm = $urandom % 2;
    if (m12) begin
      hr = ($urandom % 2) ? 11 : 1 + $urandom % 12;
      hb = {1'b1, 1'b0, 1'(pm), i2b(hr)[4:0]};
    end else begin
      hr = ($urandom % 2) ? 23 : $urandom % 24;
      hb = i2b(hr);
    end
    db = {2'b00, 1'($urandom % 2), 2'b00, 3'(1 + $urandom % 7)};
    return {i2b(yr), i2b(mo), i2b(dt), db, hb,
            i2b(($urandom % 2) ? 59 : $urandom % 60),
            i2b(($urandom % 2) ? 59 : $urandom % 60),
            i2b(90 + $urandom % 10)};
  endfunction

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expV = 64'h00_01_01_31_00_00_00_00;
    check("R1");
    for (int i = 0; i < 4; i++) cyc(1'b1, "R1 R9 halted at reset");

    load(64'hFF_FF_FF_FF_FF_FF_FF_FF, 1'b0, "R11");
    for (int i = 0; i < 3; i++) cyc(1'b1, "R9 R11");

    load(64'h00_01_15_03_23_59_59_98, 1'b0, "R10");
    cyc(1'b1, "R2");
    cyc(1'b0, "R2 idle");
    cyc(1'b1, "R3 midnight");

    load(64'h21_04_30_02_23_59_59_99, 1'b0, "R6");
    cyc(1'b1, "R6 april end");
    load(64'h21_01_30_02_23_59_59_99, 1'b0, "R6");
    cyc(1'b1, "R6 january 30");

    load(64'h23_02_28_02_23_59_59_99, 1'b0, "R7");
    cyc(1'b1, "R7 non-leap");
    load(64'h24_02_28_02_23_59_59_99, 1'b0, "R7");
    cyc(1'b1, "R7 leap 24");
    load(64'h00_02_29_02_23_59_59_99, 1'b0, "R7");
    cyc(1'b1, "R7 leap 00");
    load(64'h12_02_28_02_23_59_59_99, 1'b0, "R7");
    cyc(1'b1, "R7 leap 12");

    load(64'h99_12_31_07_23_59_59_99, 1'b0, "R8");
    cyc(1'b1, "R8 year wrap");
    load(64'h05_03_09_17_23_59_59_99, 1'b0, "R5");
    cyc(1'b1, "R5 dow wrap");

    load(64'h05_03_09_02_91_59_59_99, 1'b0, "R4");
    cyc(1'b1, "R4 11AM to 12PM");
    load(64'h05_03_09_02_B2_59_59_99, 1'b0, "R4");
    cyc(1'b1, "R4 12PM to 1PM");
    load(64'h05_03_31_02_B1_59_59_99, 1'b0, "R4");
    cyc(1'b1, "R4 11PM to 12AM");
    load(64'h05_03_09_02_92_59_59_99, 1'b0, "R4");
    cyc(1'b1, "R4 12AM to 1AM");

    load(64'h05_03_09_02_12_30_15_40, 1'b1, "R10 tick dropped");
    cyc(1'b0, "R10");

    load(64'h05_03_09_22_23_59_59_99, 1'b0, "R9");
    for (int i = 0; i < 3; i++) cyc(1'b1, "R9 halted");

    for (int trial = 0; trial < 60; trial++) begin
      load(randState(), 1'($urandom % 2), "R10 random");
      for (int c = 0; c < 150; c++) cyc(1'($urandom % 3 != 0), "R2 random run");
    end

    finish();
  end
endmodule